// File: doc/BRIEF.md
# Mode-configurable SPI master controller

The block is a single-master SPI controller that swaps one byte in full duplex with one of several slaves. A user-side strobe starts a transfer and supplies the byte to send and the index of the target slave. The block then pulls that slave's active-low select line low. It toggles the serial clock at a rate divided down from the system clock, drives the outgoing data line and samples the incoming one. It reports the received byte with a one-cycle done pulse and holds a busy flag for the length of the exchange.

Data moves through a single shift register that forms a ring with the slave's register of the same length. On every shift the register moves one place toward bit 0. Bit 0 is the bit presented on the outgoing line, and the captured incoming bit enters the top bit. After one byte of clock pulses, each side holds the byte the other side had loaded. Clock polarity and clock phase are runtime inputs that are taken at the start of a transfer, so all four SPI modes are available on every transfer.

Top module: `spi_xfer_master`

## Requirements
- R1: A start strobe while idle is accepted. From the next cycle busy is high, the addressed select is low and the transmit byte is latched.
- R2: Data goes out least-significant bit first and incoming bits enter the most-significant position. At the end of a transfer the slave holds the transmitted byte and the received-data output holds the byte the slave had loaded.
- R3: Each transfer produces exactly 2*DATA_W serial clock edges, that is DATA_W full pulses.
- R4: With cpol_i = 0 the serial clock rests low, and with cpol_i = 1 it rests high. This holds before, between and after transfers.
- R5: With cpha_i = 0 the first data bit is on the outgoing line when the select falls, incoming data is sampled on each leading edge and outgoing data changes on each trailing edge. With cpha_i = 1 outgoing data changes on each leading edge and incoming data is sampled on each trailing edge.
- R6: Only the select whose index was given at start goes low. All other selects stay high for the whole transfer.
- R7: Each half-period of the serial clock lasts HALF_DIV system clocks, measured from the accepted start. The select stays low for exactly (2*DATA_W+1)*HALF_DIV cycles, so it rises one half-period after the last edge.
- R8: When the select rises, busy falls and done is high for exactly one cycle. The received byte is valid in that cycle.
- R9: A start strobe that arrives while busy is high is ignored. The transfer in flight keeps its byte, its slave and its length.
- R10: While reset is asserted all selects are high and busy, done and the serial clock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| tx_data_i | input | DATA_W | Byte to send |
| slave_idx_i | input | SEL_W | Index of the slave to address |
| cpol_i | input | 1 | Clock resting level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| rx_data_o | output | DATA_W | Byte received in the last transfer |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| busy_o | output | 1 | High while a transfer is in progress |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data toward the slaves |
| miso_i | input | 1 | Serial data from the slaves |
| ss_n_o | output | NUM_SS | Per-slave select lines, active low |

## Verification
A behavioural slave in the bench follows the serial clock in whichever mode the transfer uses. Each of the four modes is driven with the same pair of bytes. A mode mix-up therefore shows up as a wrong or bit-shifted byte on one side only. All-zero against all-ones bytes show whether the first and last bits are dropped or duplicated, and an alternating pattern shows whether bit order is reversed. A second strobe sent mid-transfer with a different byte and slave index checks that the first transfer is left alone. Randomly drawn bytes, indices and modes then cover the general case, while edge counts and select-low time are compared against values derived from the divider setting.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/spi_half_div.sv
module spi_half_div #(
  parameter int unsigned HALF_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !en_i)     cnt_q <= '0;
    else if (cnt_q == LAST)      cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  // R7
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/spi_ring_shreg.sv
module spi_ring_shreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              in_bit_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= load_data_i;
    else if (shift_i) q_q <= {in_bit_i, q_q[DATA_W-1:1]};
  end

  assign q_o = q_q;
endmodule

// File: rtl/spi_sel_drv.sv
module spi_sel_drv #(
  parameter int unsigned NUM_SS = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [SEL_W-1:0] idx_i,
  input  logic             clr_i,
  output logic [NUM_SS-1:0] ss_n_o
);
  for (genvar g = 0; g < NUM_SS; g++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ss_n_o[g] <= 1'b1;
      else if (set_i)  ss_n_o[g] <= (idx_i != SEL_W'(g));
      else if (clr_i)  ss_n_o[g] <= 1'b1;
    end
  end

  // R6
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ss_n_o));
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_SS   = 4,
  parameter int unsigned HALF_DIV = 3,
  parameter int unsigned SEL_W    = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [SEL_W-1:0]  slave_idx_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_n_o
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned ECW   = $clog2(EDGES + 2);

  xfer_state_e       state_q;
  logic              busy, accept, tick;
  logic              last_tick, edge_tick, lead_tick, trail_tick;
  logic [ECW-1:0]    tick_cnt_q;
  logic              cpha_q, sck_q, mosi_q, samp_q, done_q;
  logic [DATA_W-1:0] shreg, rx_q;

  assign busy   = (state_q == ST_XFER);
  assign accept = start_i && !busy;

  spi_half_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .clr_i  (accept),
    .tick_o (tick)
  );

  // tick_cnt_q = half-periods already elapsed; even count -> next edge is leading
  assign last_tick  = tick && (tick_cnt_q == ECW'(EDGES));
  assign edge_tick  = tick && !last_tick;
  assign lead_tick  = edge_tick && !tick_cnt_q[0];
  assign trail_tick = edge_tick && tick_cnt_q[0];

  spi_ring_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i (tx_data_i),
    .shift_i     (trail_tick),
    .in_bit_i    (cpha_q ? miso_i : samp_q),
    .q_o         (shreg)
  );

  spi_sel_drv #(.NUM_SS(NUM_SS), .SEL_W(SEL_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accept),
    .idx_i  (slave_idx_i),
    .clr_i  (last_tick),
    .ss_n_o (ss_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tick_cnt_q <= '0;
      cpha_q     <= 1'b0;
      done_q     <= 1'b0;
      rx_q       <= '0;
    end else begin
      done_q <= last_tick;
      if (accept) begin
        state_q    <= ST_XFER;
        tick_cnt_q <= '0;
        cpha_q     <= cpha_i;
      end else if (tick) begin
        tick_cnt_q <= tick_cnt_q + 1'b1;
        if (last_tick) begin
          state_q <= ST_IDLE;
          rx_q    <= shreg;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sck_q <= 1'b0;
    else if (!busy)     sck_q <= cpol_i;
    else if (edge_tick) sck_q <= ~sck_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        samp_q <= 1'b0;
    else if (lead_tick) samp_q <= miso_i;
  end

  // phase 0: next bit after each trailing shift; phase 1: bit launched on leading edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                   mosi_q <= 1'b0;
    else if (accept)                                               mosi_q <= tx_data_i[0];
    else if (!cpha_q && trail_tick && tick_cnt_q != ECW'(EDGES-1)) mosi_q <= shreg[1];
    else if (cpha_q && lead_tick)                                  mosi_q <= shreg[0];
  end

  assign rx_data_o = rx_q;
  assign done_o    = done_q;
  assign busy_o    = busy;
  assign sck_o     = sck_q;
  assign mosi_o    = mosi_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8
  done_with_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_q && (&ss_n_o));
  // R6
  sel_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(&ss_n_o));
  // R7
  sck_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !tick |=> $stable(sck_q));
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !last_tick |=> busy && $stable(ss_n_o));
endmodule

// File: tb/spi_xfer_master_tb.sv
`timescale 1ns/1ps
module spi_xfer_master_tb_top;
  localparam int DW = 8;
  localparam int NS = 4;
  localparam int HD = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] tx = '0;
  logic [SW-1:0] idx = '0;
  logic          cpol = 1'b0;
  logic          cpha = 1'b0;
  logic          miso = 1'b0;
  logic [DW-1:0] rx;
  logic          done, busy, sck, mosi;
  logic [NS-1:0] ss_n;

  always #2.5 clk = ~clk;

  spi_xfer_master #(.DATA_W(DW), .NUM_SS(NS), .HALF_DIV(HD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_data_i(tx),
    .slave_idx_i(idx), .cpol_i(cpol), .cpha_i(cpha), .rx_data_o(rx),
    .done_o(done), .busy_o(busy), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .ss_n_o(ss_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_edges();
    return 2 * DW;
  endfunction

  function automatic int exp_low_cycles();
    return (2 * DW + 1) * HD;
  endfunction

  // behavioural slave
  logic [DW-1:0] s_pre = '0;
  logic [DW-1:0] s_reg = '0;
  logic          s_samp = 1'b0;
  logic [SW-1:0] cur_idx = '0;
  int            edges = 0;
  int            low_cyc = 0;
  int            other_low = 0;
  logic          prev_sck = 1'b0;
  logic          prev_sel = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic sel;
      for (int i = 0; i < NS; i++)
        if (i != int'(cur_idx) && !ss_n[i]) other_low++;
      sel = !ss_n[cur_idx];
      if (sel && !prev_sel) begin
        s_reg   = s_pre;
        edges   = 0;
        low_cyc = 0;
        miso    = s_reg[0];
      end
      if (sel) begin
        low_cyc++;
        if (sck != prev_sck) begin
          edges++;
          if (sck != cpol) begin
            if (!cpha) s_samp = mosi;
            else       miso = s_reg[0];
          end else begin
            if (!cpha) begin
              s_reg = {s_samp, s_reg[DW-1:1]};
              miso  = s_reg[0];
            end else begin
              s_reg = {mosi, s_reg[DW-1:1]};
            end
          end
        end
      end
      prev_sck = sck;
      prev_sel = sel;
    end
  end

  task automatic xfer(input logic [DW-1:0] tx_v, input logic [SW-1:0] idx_v,
                      input logic pol, input logic pha, input logic [DW-1:0] sb,
                      input bit poke);
    int w;
    @(negedge clk);
    cpol = pol; cpha = pha; cur_idx = idx_v; s_pre = sb; other_low = 0;
    repeat (3) @(negedge clk);
    check(sck == pol, "R4", "idle sck", sck, pol);
    tx = tx_v; idx = idx_v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !ss_n[idx_v], "R1", "busy/select after start", {busy, ss_n[idx_v]}, 2'b10);
    if (!pha) check(mosi == tx_v[0], "R5", "first bit at select fall", mosi, tx_v[0]);
    if (poke) begin
      repeat (5) @(negedge clk);
      tx = ~tx_v; idx = idx_v + 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, "R8", "done seen", done, 1);
    check(rx == sb, "R2", "received byte", rx, sb);
    check(s_reg == tx_v, poke ? "R9" : "R2", "slave got byte", s_reg, tx_v);
    check(edges == exp_edges(), poke ? "R9" : "R3", "sck edges", edges, exp_edges());
    check(low_cyc == exp_low_cycles(), "R7", "select low cycles", low_cyc, exp_low_cycles());
    check(!busy && (&ss_n), "R8", "busy/select at done", {busy, ss_n}, {1'b0, {NS{1'b1}}});
    check(other_low == 0, "R6", "foreign select low", other_low, 0);
    check(sck == pol, "R4", "sck after transfer", sck, pol);
    @(negedge clk);
    check(done == 1'b0, "R8", "done width", done, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R10
    check((&ss_n) && !busy && !done && !sck, "R10", "reset state",
          {ss_n, busy, done, sck}, {{NS{1'b1}}, 3'b000});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: all four modes, same bytes
    for (int m = 0; m < 4; m++) xfer(8'hA5, SW'(m), m[1], m[0], 8'h3C, 1'b0);
    xfer(8'h00, 2'd3, 1'b0, 1'b1, 8'hFF, 1'b0);
    xfer(8'hFF, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0);
    xfer(8'h55, 2'd1, 1'b1, 1'b1, 8'hAA, 1'b0);
    xfer(8'h01, 2'd2, 1'b0, 1'b0, 8'h80, 1'b0);
    // R9: strobe while busy
    xfer(8'hC3, 2'd2, 1'b0, 1'b0, 8'h5A, 1'b1);
    xfer(8'h96, 2'd0, 1'b1, 1'b1, 8'h69, 1'b1);
    // R4: toggle polarity while idle
    @(negedge clk); cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(sck == 1'b1, "R4", "idle sck follows polarity", sck, 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sck == 1'b0, "R4", "idle sck follows polarity", sck, 0);

    for (int n = 0; n < 24; n++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      xfer(DW'($urandom), r[1:0], r[2], r[3], DW'($urandom), 1'b0);
    end

    summary();
    $finish;
  end
endmodule